// File: doc/BRIEF.md
# Flash Page Erase Command Controller

This block sits between a register bus and a small behavioural flash array. Software selects a page by writing the page register and an in-page byte by writing the offset register. A write to the data register programs that byte, and a read of the data register returns it. A page erase starts only when the exact key byte 0x5A is written to the command register. The erase uses only the page register; the offset register plays no part in it.

While an erase runs, a busy flag is held. The erase length is counted in pulses of a separate fixed-rate tick enable, not in clock cycles. The length is set by a parameter: the default of 9400 ticks at 1 MHz gives 9.4 ms, and a bench can use a short count. When the count completes, every byte of the page becomes all ones. Each byte also carries a write counter that the controller uses to refuse bad program requests:

- a third program of a byte since its last erase;
- any program that would turn a 0 bit back into a 1.

The page that holds the running code is given on an input. Reads, programs and erases aimed at that page are refused.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the status register (offset 0) reads 0x00, busy is low and every flash byte reads 0xFF.
- R2: Writing 0x5A to the command register (offset 4) while idle, to a page other than codePage, starts an erase of the page held in the page register (offset 1), whatever the offset register (offset 2) holds; busy and status bit 0 are high from the next cycle.
- R3: Busy stays high until exactly ERASE_TICKS tickEn pulses have been sampled while busy, falling on the clock edge that takes the last one; cycles without a tick do not advance the erase.
- R4: In the cycle busy falls, every byte of the erased page reads 0xFF and its write counters restart, so each byte may again be programmed twice; other pages are unchanged.
- R5: A command byte other than 0x5A written while idle starts nothing and sets status bit 1.
- R6: A command or data-register write while busy is ignored and sets status bit 2.
- R7: A data-register (offset 3) write while idle programs the selected byte when that byte has been programmed fewer than two times since its last erase and the new value sets no bit that is currently 0.
- R8: A program that would turn any 0 bit into 1 leaves the byte unchanged and sets status bit 3.
- R9: A third program of a byte since its last erase leaves the byte unchanged and sets status bit 3.
- R10: When the page register equals codePage, data-register reads return 0x00, and program or 0x5A-command writes are ignored and set status bit 4.
- R11: Status bits 1 to 4 are sticky and any write to the status register clears all of them; busy (bit 0) is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Fixed-rate time base pulse used to time the erase |
| codePage | input | PAGE_W | Page currently holding executing code |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for the register at regAddr |
| busy | output | 1 | Erase in progress |

## Verification
The hardest condition to reach is a request that lands during an erase. This includes the moment the erase ends, when the erased page must show all ones and its write counters must already have restarted. The bench reaches it by stopping the tick source before issuing the erase command. Programs and commands are then pushed against a page that is held busy for as long as the bench needs. Ticks are then released, and the number of ticks sampled while busy is compared with the parameter when busy falls. The erased page is then programmed twice more, which shows that the counters were reset by the erase.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] REG_PAGE   = 3'd1;
  localparam logic [ADDR_W-1:0] REG_OFFSET = 3'd2;
  localparam logic [ADDR_W-1:0] REG_DATA   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_CMD    = 3'd4;

  localparam logic [REG_W-1:0] ERASE_KEY = 8'h5A;

  // sticky flag indices (status bit = index + 1)
  localparam int FLG_CMDBAD = 0;
  localparam int FLG_REJECT = 1;
  localparam int FLG_WRERR  = 2;
  localparam int FLG_PROT   = 3;
  localparam int FLG_N      = 4;

  typedef struct packed {
    logic progStb;
    logic eraseStb;
  } dpStrobe_t;
endpackage

// File: rtl/fpe_timer.sv
module fpe_timer #(
  parameter int ERASE_TICKS = 9400
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic tickEn,
  output logic busy,
  output logic done
);
  localparam int TCW = (ERASE_TICKS > 1) ? $clog2(ERASE_TICKS) : 1;
  localparam logic [TCW-1:0] LAST = TCW'(ERASE_TICKS - 1);

  logic [TCW-1:0] tickCnt;

  assign done = busy && tickEn && (tickCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      tickCnt <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      tickCnt <= '0;
    end else if (done) begin
      busy    <= 1'b0;
      tickCnt <= '0;
    end else if (busy && tickEn) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end
endmodule

// File: rtl/fpe_ctrl.sv
module fpe_ctrl
  import fpe_pkg::*;
#(
  parameter int PAGE_W = 2,
  parameter int OFF_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [PAGE_W-1:0]    codePage,
  input  logic                 progBad,
  input  logic                 timerBusy,
  input  logic                 timerDone,
  output logic                 startErase,
  output dpStrobe_t            strobe,
  output logic [PAGE_W-1:0]    pageReg,
  output logic [OFF_W-1:0]     offReg,
  output logic [PAGE_W-1:0]    erasePage,
  output logic [FLG_N-1:0]     flags
);
  logic wrStatus, wrPage, wrOff, wrData, wrCmd;
  logic keyOk, onCodePage;
  logic setCmdBad, setReject, setWrErr, setProt;

  assign wrStatus = regWrEn && (regAddr == REG_STATUS);
  assign wrPage   = regWrEn && (regAddr == REG_PAGE);
  assign wrOff    = regWrEn && (regAddr == REG_OFFSET);
  assign wrData   = regWrEn && (regAddr == REG_DATA);
  assign wrCmd    = regWrEn && (regAddr == REG_CMD);

  assign keyOk      = (regWrData == ERASE_KEY);
  assign onCodePage = (pageReg == codePage);

  assign startErase = wrCmd && !timerBusy && keyOk && !onCodePage;

  assign strobe.progStb  = wrData && !timerBusy && !onCodePage && !progBad;
  assign strobe.eraseStb = timerDone;

  assign setCmdBad = wrCmd && !timerBusy && !keyOk;
  assign setReject = (wrCmd || wrData) && timerBusy;
  assign setWrErr  = wrData && !timerBusy && !onCodePage && progBad;
  assign setProt   = !timerBusy && onCodePage && (wrData || (wrCmd && keyOk));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg   <= '0;
      offReg    <= '0;
      erasePage <= '0;
    end else begin
      if (wrPage)     pageReg   <= regWrData[PAGE_W-1:0];
      if (wrOff)      offReg    <= regWrData[OFF_W-1:0];
      if (startErase) erasePage <= pageReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else if (wrStatus) begin
      flags <= '0;
    end else begin
      if (setCmdBad) flags[FLG_CMDBAD] <= 1'b1;
      if (setReject) flags[FLG_REJECT] <= 1'b1;
      if (setWrErr)  flags[FLG_WRERR]  <= 1'b1;
      if (setProt)   flags[FLG_PROT]   <= 1'b1;
    end
  end
endmodule

// File: rtl/fpe_datapath.sv
module fpe_datapath
  import fpe_pkg::*;
#(
  parameter int PAGE_W     = 2,
  parameter int OFF_W      = 4,
  parameter int MAX_WRITES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic [OFF_W-1:0]  offSel,
  input  logic [PAGE_W-1:0] erasePage,
  input  logic [REG_W-1:0]  wrByte,
  output logic [REG_W-1:0]  rdByte,
  output logic              progBad
);
  localparam int NUM_PAGES  = 1 << PAGE_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int CNT_W      = $clog2(MAX_WRITES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_WRITES);

  logic [REG_W-1:0] pageRd  [NUM_PAGES];
  logic [CNT_W-1:0] pageCnt [NUM_PAGES];
  logic [CNT_W-1:0] curCnt;

  genvar p;
  generate
    for (p = 0; p < NUM_PAGES; p++) begin : g_page
      logic [REG_W-1:0] cells [PAGE_BYTES];
      logic [CNT_W-1:0] wrCnt [PAGE_BYTES];
      logic eraseHit, progHit;

      assign eraseHit = strobe.eraseStb && (erasePage == PAGE_W'(p));
      assign progHit  = strobe.progStb && (pageSel == PAGE_W'(p));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int b = 0; b < PAGE_BYTES; b++) begin
            cells[b] <= '1;
            wrCnt[b] <= '0;
          end
        end else if (eraseHit) begin
          for (int b = 0; b < PAGE_BYTES; b++) begin
            cells[b] <= '1;
            wrCnt[b] <= '0;
          end
        end else if (progHit) begin
          cells[offSel] <= wrByte;
          wrCnt[offSel] <= wrCnt[offSel] + 1'b1;
        end
      end

      assign pageRd[p]  = cells[offSel];
      assign pageCnt[p] = wrCnt[offSel];
    end
  endgenerate

  assign rdByte  = pageRd[pageSel];
  assign curCnt  = pageCnt[pageSel];
  assign progBad = (curCnt >= CNT_MAX) || ((wrByte & ~rdByte) != '0);
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fpe_pkg::*;
#(
  parameter int PAGE_W      = 2,
  parameter int OFF_W       = 4,
  parameter int MAX_WRITES  = 2,
  parameter int ERASE_TICKS = 9400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [PAGE_W-1:0] codePage,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              busy
);
  dpStrobe_t         strobe;
  logic [PAGE_W-1:0] pageReg, erasePage;
  logic [OFF_W-1:0]  offReg;
  logic [FLG_N-1:0]  flags;
  logic              progBad, startErase, timerDone;
  logic [REG_W-1:0]  rdByte;

  fpe_ctrl #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .codePage(codePage), .progBad(progBad),
    .timerBusy(busy), .timerDone(timerDone), .startErase(startErase),
    .strobe(strobe), .pageReg(pageReg), .offReg(offReg),
    .erasePage(erasePage), .flags(flags)
  );

  fpe_timer #(.ERASE_TICKS(ERASE_TICKS)) u_timer (
    .clk(clk), .rstN(rstN), .start(startErase), .tickEn(tickEn),
    .busy(busy), .done(timerDone)
  );

  fpe_datapath #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .MAX_WRITES(MAX_WRITES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pageSel(pageReg),
    .offSel(offReg), .erasePage(erasePage), .wrByte(regWrData),
    .rdByte(rdByte), .progBad(progBad)
  );

  always_comb begin
    case (regAddr)
      REG_STATUS: regRdData = {{(REG_W-FLG_N-1){1'b0}}, flags, busy};
      REG_PAGE:   regRdData = REG_W'(pageReg);
      REG_OFFSET: regRdData = REG_W'(offReg);
      REG_DATA:   regRdData = (pageReg == codePage) ? '0 : rdByte;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker
  import fpe_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic [7:0]        regWrData,
  input logic [PAGE_W-1:0] codePage,
  input logic [PAGE_W-1:0] pageReg,
  input logic              busy,
  input logic [FLG_N-1:0]  flags,
  input logic              progBad
);
  assert_erase_by_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrEn && regAddr == REG_CMD && regWrData == ERASE_KEY));

  assert_end_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(tickEn));

  assert_busy_reject_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && (regAddr == REG_CMD || regAddr == REG_DATA)) |=> flags[FLG_REJECT]);

  assert_bad_program_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_DATA && !busy && pageReg != codePage && progBad)
      |=> flags[FLG_WRERR]);

  assert_code_page_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_DATA && !busy && pageReg == codePage) |=> flags[FLG_PROT]);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == REG_STATUS) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind flash_erase_ctrl fpe_checker #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .codePage(codePage), .pageReg(pageReg), .busy(busy),
  .flags(flags), .progBad(progBad)
);

// File: tb/flash_erase_ctrl_tb.sv
`timescale 1ns/100ps
module flash_erase_ctrl_tb;
  localparam int PAGE_W = 2;
  localparam int OFF_W  = 4;
  localparam int TICKS  = 5;
  localparam int NP     = 1 << PAGE_W;
  localparam int PB     = 1 << OFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic [PAGE_W-1:0] codePage = 2'd3;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit tickOn = 0;
  int tickPh = 0;
  int ticksSeen = 0;

  // reference model state
  int mMem [NP*PB];
  int mCnt [NP*PB];
  int mPage, mOff, mErPage, mTickCnt;
  bit [3:0] mFlags;
  bit mBusy;

  flash_erase_ctrl #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .MAX_WRITES(2), .ERASE_TICKS(TICKS)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .codePage(codePage), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .busy(busy)
  );

  always #2.5 clk = ~clk;

  task automatic modelReset();
    for (int i = 0; i < NP*PB; i++) begin mMem[i] = 255; mCnt[i] = 0; end
    mPage = 0; mOff = 0; mErPage = 0; mTickCnt = 0; mFlags = '0; mBusy = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit ob;
      int idx;
      ob = mBusy;
      if (ob && tickEn) begin
        if (mTickCnt == TICKS - 1) begin
          for (int b = 0; b < PB; b++) begin mMem[mErPage*PB+b] = 255; mCnt[mErPage*PB+b] = 0; end
          mBusy = 0;
        end else mTickCnt++;
      end
      if (regWrEn) begin
        idx = mPage*PB + mOff;
        case (regAddr)
          3'd0: mFlags = '0;
          3'd1: mPage = int'(regWrData) % NP;
          3'd2: mOff = int'(regWrData) % PB;
          3'd3: begin
            if (ob) mFlags[1] = 1;
            else if (mPage == int'(codePage)) mFlags[3] = 1;
            else if (mCnt[idx] >= 2 || ((int'(regWrData) & ~mMem[idx] & 255) != 0)) mFlags[2] = 1;
            else begin mMem[idx] = int'(regWrData); mCnt[idx]++; end
          end
          3'd4: begin
            if (ob) mFlags[1] = 1;
            else if (regWrData != 8'h5A) mFlags[0] = 1;
            else if (mPage == int'(codePage)) mFlags[3] = 1;
            else begin mBusy = 1; mTickCnt = 0; mErPage = mPage; end
          end
          default: ;
        endcase
      end
    end
  end

  function automatic int expRd(input logic [2:0] a);
    case (a)
      3'd0: return int'({3'b000, mFlags, mBusy});
      3'd1: return mPage;
      3'd2: return mOff;
      3'd3: return (mPage == int'(codePage)) ? 0 : mMem[mPage*PB + mOff];
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("MODEL busy", int'(busy), int'(mBusy));
      check("MODEL rdata", int'(regRdData), expRd(regAddr));
      if (tickEn && busy) ticksSeen++;
    end
  end

  // time base
  always @(posedge clk) begin
    #1;
    tickPh = (tickPh + 1) % 4;
    tickEn = tickOn && (tickPh == 0);
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    regAddr = a;
    @(negedge clk);
    check(tag, int'(regRdData), exp);
    @(posedge clk); #1;
  endtask

  task automatic sel(input int page, input int off);
    wr(3'd1, 8'(page));
    wr(3'd2, 8'(off));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL WATCHDOG run did not complete");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;

    rd(3'd0, 8'h00, "R1 status after reset");
    check("R1 busy after reset", int'(busy), 0);
    rd(3'd3, 8'hFF, "R1 erased byte after reset");

    sel(1, 5);
    wr(3'd3, 8'hF0);
    rd(3'd3, 8'hF0, "R7 first program");
    wr(3'd3, 8'h30);
    rd(3'd3, 8'h30, "R7 second program clears more bits");
    rd(3'd0, 8'h00, "R7 no error after valid programs");

    wr(3'd3, 8'h10);
    rd(3'd3, 8'h30, "R9 third program refused");
    rd(3'd0, 8'h08, "R9 write error flag");
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h00, "R11 status write clears flags");

    wr(3'd2, 8'd6);
    wr(3'd3, 8'hAA);
    wr(3'd3, 8'h55);
    rd(3'd3, 8'hAA, "R8 zero-to-one program refused");
    rd(3'd0, 8'h08, "R8 write error flag");
    wr(3'd0, 8'h00);

    sel(0, 0);
    wr(3'd3, 8'h12);
    sel(1, 5);

    wr(3'd4, 8'h33);
    rd(3'd0, 8'h02, "R5 bad command flag, no erase");
    wr(3'd0, 8'h00);

    // erase with the time base stopped
    tickOn = 0;
    wr(3'd4, 8'h5A);
    rd(3'd0, 8'h01, "R2 busy right after key");
    repeat (40) @(posedge clk);
    #1;
    check("R3 no progress without ticks", int'(busy), 1);
    wr(3'd3, 8'h00);
    rd(3'd0, 8'h05, "R6 program while busy rejected");
    rd(3'd3, 8'h30, "R6 byte unchanged while busy");
    wr(3'd4, 8'h5A);
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h01, "R11 clear keeps busy");

    ticksSeen = 0;
    tickOn = 1;
    while (busy) begin @(posedge clk); #1; end
    check("R3 ticks counted while busy", ticksSeen, TICKS);
    tickOn = 0;

    rd(3'd3, 8'hFF, "R4 erased byte 5");
    wr(3'd2, 8'd6);
    rd(3'd3, 8'hFF, "R4 erased byte 6");
    sel(0, 0);
    rd(3'd3, 8'h12, "R4 other page untouched");
    sel(1, 5);
    wr(3'd3, 8'h0F);
    wr(3'd3, 8'h0E);
    rd(3'd3, 8'h0E, "R4 counters restart after erase");
    rd(3'd0, 8'h00, "R4 no error after re-program");

    sel(3, 2);
    rd(3'd3, 8'h00, "R10 read of code page blocked");
    wr(3'd3, 8'h00);
    rd(3'd0, 8'h10, "R10 program of code page flagged");
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h5A);
    rd(3'd0, 8'h10, "R10 erase of code page refused");
    sel(0, 0);
    rd(3'd3, 8'h12, "R10 array intact");

    repeat (4) @(posedge clk);
    finished = 1;
    summary();
  end
endmodule